// File: doc/BRIEF.md
# Five-Level Inverter Gate Pattern Generator

This block drives the six power switches of a single-phase five-level inverter built from a two-switch level stage feeding an H-bridge. The two level switches (S1, S2) run at carrier rate: each compares a sinusoidal reference magnitude against its own triangular carrier, and the second carrier runs half a carrier period behind the first. The H-bridge pairs (S3/S6 and S4/S5) change state only at the fundamental rate and pick the output polarity from the sign of the reference. When the pairs change over, a programmable dead time applies.

The reference is a computed parabolic sine approximation with 2^(HALF_W+1) samples per fundamental period. Each sample is held for `fund_div` clocks and scaled by a modulation index into the carrier range. Because the carriers are half a period apart, the half-magnitude output level is produced alternately through S1 alone and S2 alone. This shares charge and discharge between the two series capacitors without any sensing. A one-clock strobe marks each zero crossing of the reference.

Top module: `fivelvl_gate_gen`

## Requirements
- R1: While `rst_n` is low, all seven outputs are 0. One clock after any edge at which `enable` is sampled low, all seven outputs are 0.
- R2: The sample index starts at 0 on the first enabled clock. It advances by one after every `fund_div` enabled clocks and wraps after 2*2^HALF_W samples. Indices below 2^HALF_W form the positive half; the rest form the negative half.
- R3: Take k = index mod 2^HALF_W and H = 2^HALF_W. The reference magnitude is floor(4*k*(H-k)*`mod_index`*`car_top` / (H*H*2^MI_W)). It is therefore 0 at every zero crossing.
- R4: Carrier A starts at 0 and rises by one per enabled clock to `car_top`, then falls to 0, and repeats. Carrier B starts at `car_top` and falls, so that A+B equals `car_top` on every clock.
- R5: `gate_s1` equals (reference > carrier A) and `gate_s2` equals (reference > carrier B). Both are evaluated on the index and carriers of the previous clock. A zero reference keeps both off.
- R6: In the positive half `gate_s3` and `gate_s6` are on; in the negative half `gate_s4` and `gate_s5` are on. `gate_s3` always equals `gate_s6`, `gate_s4` always equals `gate_s5`, and the two pairs are never on together.
- R7: When the sign of the index changes, both pairs are off for `dead_time`+1 clocks before the new pair turns on. The first enabled clock from disable turns on the positive pair without dead time.
- R8: `sync` is high for exactly one clock, in the clock where the index has just advanced to 0 or to 2^HALF_W.
- R9: With 0 < reference < `car_top` over part of a half cycle, both the S1-only state and the S2-only state occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run; low forces all gates off and restarts the phase |
| mod_index | input | MI_W | Modulation index, fraction of 2^MI_W |
| car_top | input | CNT_W | Carrier peak; triangle period is 2*car_top clocks |
| fund_div | input | DIV_W | Clocks per reference sample |
| dead_time | input | DT_W | Extra off clocks at each polarity change |
| gate_s1 | output | 1 | Level switch on carrier A |
| gate_s2 | output | 1 | Level switch on carrier B |
| gate_s3 | output | 1 | Positive polarity pair, first switch |
| gate_s4 | output | 1 | Negative polarity pair, first switch |
| gate_s5 | output | 1 | Negative polarity pair, second switch |
| gate_s6 | output | 1 | Positive polarity pair, second switch |
| sync | output | 1 | One-clock zero-crossing strobe |

## Verification
The assertions assume that `car_top` is at least 1, `fund_div` is at least 1, and neither is changed while `enable` is high. The carrier-sum property also assumes that at least one disabled clock has passed since reset, so that both carriers have been loaded from `car_top`. The bench keeps within these limits: it deasserts `enable`, holds it low for two clocks, changes the configuration only during that window, and only then raises `enable` again. Disabling in the middle of a cycle is exercised the same way.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef struct packed {
        logic a_on;
        logic b_on;
    } lvl_t;
endpackage

// File: rtl/fl_phase_gen.sv
module fl_phase_gen #(
    parameter int HALF_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  fund_div,
    output logic [HALF_W:0]   phase,
    output logic              sync
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [HALF_W:0]  ph;
        logic             sync;
    } st_t;

    st_t st_d, st_q;
    logic [HALF_W:0] ph_inc;

    always_comb begin
        st_d   = st_q;
        ph_inc = st_q.ph + 1'b1;
        if (!run) begin
            st_d = '0;
        end else begin
            st_d.sync = 1'b0;
            if (({1'b0, st_q.div} + 1'b1) >= {1'b0, fund_div}) begin
                st_d.div  = '0;
                st_d.ph   = ph_inc;
                st_d.sync = (ph_inc[HALF_W-1:0] == '0);
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign sync  = st_q.sync;
endmodule

// File: rtl/fl_carrier.sv
module fl_carrier #(
    parameter int CNT_W      = 12,
    parameter bit START_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = START_HIGH ? top : '0;
            st_d.up  = !START_HIGH;
        end else if (st_q.up) begin
            if (st_q.cnt >= top) begin
                st_d.cnt = top;
                st_d.up  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.up  = ((st_q.cnt + 1'b1) != top);
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.up = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
                st_d.up  = (st_q.cnt == 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.up  <= !START_HIGH;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;
endmodule

// File: rtl/fl_sine_ref.sv
module fl_sine_ref #(
    parameter int HALF_W = 4,
    parameter int MI_W   = 8,
    parameter int CNT_W  = 12
) (
    input  logic [HALF_W-1:0] k,
    input  logic [MI_W-1:0]   mod_index,
    input  logic [CNT_W-1:0]  top,
    output logic [CNT_W-1:0]  mag
);
    localparam int BASE_W = 2 * HALF_W + 3;
    localparam int PROD_W = BASE_W + MI_W + CNT_W;
    localparam int SHIFT  = 2 * HALF_W + MI_W;
    localparam logic [HALF_W:0] HALF = (HALF_W+1)'(1) << HALF_W;

    logic [HALF_W:0]   kk, rest;
    logic [BASE_W-1:0] base;
    logic [PROD_W-1:0] prod;

    always_comb begin
        kk   = {1'b0, k};
        rest = HALF - kk;
        base = (BASE_W'(kk) * BASE_W'(rest)) << 2;
        prod = PROD_W'(base) * PROD_W'(mod_index) * PROD_W'(top);
        mag  = CNT_W'(prod >> SHIFT);
    end
endmodule

// File: rtl/fl_polarity.sv
module fl_polarity #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            neg_half,
    input  logic [DT_W-1:0] dead_time,
    output logic            pos_on,
    output logic            neg_on,
    output logic            pol
);
    typedef struct packed {
        logic            pol;
        logic [DT_W-1:0] dead;
        logic            pos;
        logic            neg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (neg_half != st_q.pol) begin
            st_d.pol  = neg_half;
            st_d.dead = dead_time;
            st_d.pos  = 1'b0;
            st_d.neg  = 1'b0;
        end else begin
            st_d.pos  = !neg_half && (st_q.dead == '0);
            st_d.neg  = neg_half && (st_q.dead == '0);
            st_d.dead = (st_q.dead != '0) ? st_q.dead - 1'b1 : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_on = st_q.pos;
    assign neg_on = st_q.neg;
    assign pol    = st_q.pol;
endmodule

// File: rtl/fivelvl_gate_gen.sv
module fivelvl_gate_gen #(
    parameter int HALF_W = 4,
    parameter int MI_W   = 8,
    parameter int CNT_W  = 12,
    parameter int DIV_W  = 8,
    parameter int DT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [MI_W-1:0]  mod_index,
    input  logic [CNT_W-1:0] car_top,
    input  logic [DIV_W-1:0] fund_div,
    input  logic [DT_W-1:0]  dead_time,
    output logic             gate_s1,
    output logic             gate_s2,
    output logic             gate_s3,
    output logic             gate_s4,
    output logic             gate_s5,
    output logic             gate_s6,
    output logic             sync
);
    import fl_pkg::*;

    logic [HALF_W:0]  phase_w;
    logic [CNT_W-1:0] car_a, car_b, ref_mag;
    logic             pos_on, neg_on, pol_w;
    lvl_t             lvl_d, lvl_q;

    fl_phase_gen #(.HALF_W(HALF_W), .DIV_W(DIV_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(enable), .fund_div(fund_div),
        .phase(phase_w), .sync(sync)
    );

    fl_carrier #(.CNT_W(CNT_W), .START_HIGH(1'b0)) u_car_a (
        .clk(clk), .rst_n(rst_n), .run(enable), .top(car_top), .value(car_a)
    );

    fl_carrier #(.CNT_W(CNT_W), .START_HIGH(1'b1)) u_car_b (
        .clk(clk), .rst_n(rst_n), .run(enable), .top(car_top), .value(car_b)
    );

    fl_sine_ref #(.HALF_W(HALF_W), .MI_W(MI_W), .CNT_W(CNT_W)) u_ref (
        .k(phase_w[HALF_W-1:0]), .mod_index(mod_index), .top(car_top), .mag(ref_mag)
    );

    fl_polarity #(.DT_W(DT_W)) u_pol (
        .clk(clk), .rst_n(rst_n), .run(enable), .neg_half(phase_w[HALF_W]),
        .dead_time(dead_time), .pos_on(pos_on), .neg_on(neg_on), .pol(pol_w)
    );

    always_comb begin
        lvl_d = '0;
        if (enable) begin
            lvl_d.a_on = (ref_mag > car_a);
            lvl_d.b_on = (ref_mag > car_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign gate_s1 = lvl_q.a_on;
    assign gate_s2 = lvl_q.b_on;
    assign gate_s3 = pos_on;
    assign gate_s6 = pos_on;
    assign gate_s4 = neg_on;
    assign gate_s5 = neg_on;
endmodule

// File: rtl/fl_gate_checker.sv
module fl_gate_checker #(
    parameter int HALF_W = 4,
    parameter int CNT_W  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] car_top,
    input logic [HALF_W:0]  phase,
    input logic [CNT_W-1:0] car_a,
    input logic [CNT_W-1:0] car_b,
    input logic [CNT_W-1:0] ref_mag,
    input logic             pol,
    input logic             g1,
    input logic             g2,
    input logic             g3,
    input logic             g4,
    input logic             g5,
    input logic             g6,
    input logic             sync
);
    logic loaded_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loaded_q <= 1'b0;
        else        loaded_q <= loaded_q | !enable;
    end

    p_gates_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(g1 | g2 | g3 | g4 | g5 | g6 | sync));

    p_carrier_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && $stable(car_top)) |-> ((CNT_W+1)'(car_a) + (CNT_W+1)'(car_b) == (CNT_W+1)'(car_top)));

    p_zero_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_mag == '0) |=> !(g1 | g2));

    p_pair_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (g3 == g6) && (g4 == g5) && !(g3 && g4));

    p_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (phase[HALF_W] != pol)) |=> !(g3 | g4 | g5 | g6));

    p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (phase[HALF_W-1:0] == '0));
endmodule

bind fivelvl_gate_gen fl_gate_checker #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .car_top(car_top),
    .phase(phase_w), .car_a(car_a), .car_b(car_b), .ref_mag(ref_mag), .pol(pol_w),
    .g1(gate_s1), .g2(gate_s2), .g3(gate_s3), .g4(gate_s4), .g5(gate_s5),
    .g6(gate_s6), .sync(sync)
);

// File: tb/fivelvl_gate_gen_test.sv
`timescale 1ns/1ps
module fivelvl_gate_gen_test;
    localparam int HW   = 4;
    localparam int HALF = 1 << HW;
    localparam int MIW  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] mod_index = '0;
    logic [11:0] car_top = 12'd5;
    logic [7:0] fund_div = 8'd1;
    logic [3:0] dead_time = '0;
    logic g1, g2, g3, g4, g5, g6, sync;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state
    int m_phase, m_div, m_a, m_b, m_dead;
    bit m_aup, m_bup, m_pol;
    bit e1, e2, epos, eneg, esync;
    int only1, only2;

    always #2.5 clk = ~clk;

    fivelvl_gate_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mod_index(mod_index),
        .car_top(car_top), .fund_div(fund_div), .dead_time(dead_time),
        .gate_s1(g1), .gate_s2(g2), .gate_s3(g3), .gate_s4(g4),
        .gate_s5(g5), .gate_s6(g6), .sync(sync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3: parabolic reference scaled into carrier range
    function automatic int ref_of(input int k);
        longint b = 4 * k * (HALF - k);
        return int'((b * longint'(mod_index) * longint'(car_top)) >>> (2 * HW + MIW));
    endfunction

    task automatic model_tick();
        int k, r;
        bit neg;
        if (!enable) begin
            {e1, e2, epos, eneg, esync} = '0;
            m_phase = 0; m_div = 0; m_pol = 0; m_dead = 0;
            m_a = 0; m_aup = 1; m_b = car_top; m_bup = 0;
        end else begin
            k   = m_phase % HALF;
            neg = (m_phase >= HALF);
            r   = ref_of(k);
            e1  = r > m_a;   // R5
            e2  = r > m_b;
            if (neg != m_pol) begin          // R7
                epos = 0; eneg = 0; m_pol = neg; m_dead = dead_time;
            end else begin                   // R6
                epos = !neg && (m_dead == 0);
                eneg = neg && (m_dead == 0);
                if (m_dead > 0) m_dead--;
            end
            // R4 carriers
            if (m_aup) begin m_a++; m_aup = (m_a != car_top); end
            else       begin m_a--; m_aup = (m_a == 0); end
            if (m_bup) begin m_b++; m_bup = (m_b != car_top); end
            else       begin m_b--; m_bup = (m_b == 0); end
            // R2 phase, R8 sync
            if (m_div + 1 >= fund_div) begin
                m_div = 0;
                m_phase = (m_phase + 1) % (2 * HALF);
                esync = (m_phase % HALF == 0);
            end else begin
                m_div++;
                esync = 0;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        check({g1, g2} == {e1, e2}, enable ? "R5 level gates (R2 R3 R4)" : "R1 level gates off",
              int'({g1, g2}), int'({e1, e2}));
        check({g3, g6, g4, g5} == {epos, epos, eneg, eneg},
              (!epos && !eneg && enable) ? "R7 polarity dead time" : "R6 polarity pairs",
              int'({g3, g6, g4, g5}), int'({epos, epos, eneg, eneg}));
        check(sync == esync, "R8 sync strobe", int'(sync), int'(esync));
        if (g1 && !g2) only1++;
        if (g2 && !g1) only2++;
    endtask

    task automatic run_cfg(input int mi, input int top, input int div, input int dt, input int clocks);
        enable = 0;
        tick();
        mod_index = 8'(mi); car_top = 12'(top); fund_div = 8'(div); dead_time = 4'(dt);
        tick();
        tick();
        enable = 1;
        for (int i = 0; i < clocks; i++) tick();
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_phase = 0; m_div = 0; m_a = 0; m_b = 0; m_aup = 1; m_bup = 0; m_pol = 0; m_dead = 0;
        only1 = 0; only2 = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({g1, g2, g3, g4, g5, g6, sync} == 7'b0, "R1 reset outputs", int'({g1, g2, g3, g4, g5, g6, sync}), 0);
        rst_n = 1;
        // Mid-range index, dead time 2, two fundamental periods
        run_cfg(128, 5, 3, 2, 2 * 2 * HALF * 3);
        // R9 alternating half-level states
        check(only1 > 0 && only2 > 0, "R9 S1-only and S2-only both seen", only1 * 1000 + only2, 1);
        // Near-full index, no dead time
        run_cfg(255, 4, 2, 0, 2 * 2 * HALF * 2);
        // Zero index: level gates stay off (R5)
        run_cfg(0, 6, 1, 1, 2 * 2 * HALF);
        // Disable mid-cycle then restart (R1, R2 restart)
        run_cfg(200, 7, 4, 3, HALF * 4 + 5);
        run_cfg(200, 7, 4, 3, 2 * 2 * HALF * 4);
        // Carrier peak of one, long dead time
        run_cfg(180, 1, 5, 9, 2 * 2 * HALF * 5);
        enable = 0;
        tick();
        tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1;
        $finish;
    end
endmodule